// File: doc/BRIEF.md
# Cascadable 13-Bit Interval Timer

This block is a general-purpose interval timer built around a 13-bit down-counter and one 16-bit control word. Software writes the control word to set a start value, pick the tick source, start or stop counting, and switch the timer off for good. The counter steps down once per tick. The tick is either every second system clock or a tick strobe from an external prescaler chain. Using that strobe lets the timer act as the upper half of a longer counter.

When a count expires, the block raises a one-clock interrupt pulse and starts counting again from the programmed value. A programmed value of zero parks the counter at zero, and no interrupt is ever raised. The off switch is sticky: once software clears it, only a reset turns it back on. Every write restarts counting from the newly written value. The control word and the live count are both visible on output ports.

Top module: `tmr13_top`

## Requirements
- R1: During and after reset, cfg_o reads 16'h8000 (enabled, not counting, half-rate source, value 0), count_o reads 0 and irq_o is low.
- R2: The control word layout is: bits 12:0 are the start value, bit 13 is the source (0 = half-rate system clock, 1 = cascade tick), bit 14 is run, and bit 15 is enable. A write with wr_en_i high stores the word at the next clock edge and loads count_o with bits 12:0 at that same edge.
- R3: count_o steps only while both enable (bit 15) and run (bit 14) are 1. Otherwise it holds its value.
- R4: After enable has been written to 0, a later write with bit 15 at 1 leaves cfg_o bit 15 at 0. Only a reset sets it again. The other bits of that write are still stored.
- R5: With the half-rate source and start value N>0, irq_o is high in the 2N-th cycle after the write edge, then again every 2N cycles.
- R6: With the cascade source, count_o steps down once for each clock edge at which casc_tick_i is high. After N such edges irq_o pulses.
- R7: Expiry happens on a tick with count_o equal to 1. irq_o is then high for exactly one cycle, and count_o reloads the programmed value in that same cycle.
- R8: With a programmed value of 0, count_o stays at 0 and irq_o never rises.
- R9: A write restarts counting: it resets the half-rate phase, and a write at the edge where an expiry would occur suppresses that interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word to write |
| casc_tick_i | input | 1 | Tick strobe from an external prescaler chain |
| cfg_o | output | 16 | Stored control word |
| count_o | output | 13 | Current count |
| irq_o | output | 1 | Expiry pulse, one clock wide |

## Verification
The hardest case to reach from the ports is a write that lands on the very edge where a count of one would expire. That collision needs the half-rate phase and the write strobe to line up exactly. The bench reaches it with a directed sequence: a start value of 1, then a rewrite two edges later. A similar problem is the sticky enable, which locks the block once it is cleared. For that reason the random phase keeps enable set, and the clearing and the attempted re-enable run last, followed by a reset.

// File: rtl/tmr13_pkg.sv
package tmr13_pkg;
  typedef enum logic {
    SRC_HALF = 1'b0,
    SRC_CASC = 1'b1
  } tick_src_e;
endpackage

// File: rtl/tmr13_cfg_reg.sv
module tmr13_cfg_reg #(
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] cfg_o
);
  localparam int EN_BIT = REG_W - 1;
  localparam logic [REG_W-1:0] RST_VAL = {1'b1, {(REG_W-1){1'b0}}};

  logic [REG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= RST_VAL;
    end else if (wr_en_i) begin
      // enable can only be cleared by software
      cfg_q <= {cfg_q[EN_BIT] & wr_data_i[EN_BIT], wr_data_i[EN_BIT-1:0]};
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/tmr13_tick_gen.sv
module tmr13_tick_gen
  import tmr13_pkg::*;
#(
  parameter bit CASC_SYNC = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      active_i,
  input  tick_src_e src_i,
  input  logic      restart_i,
  input  logic      casc_tick_i,
  output logic      tick_o
);
  logic phase_q;
  logic casc_tick;

  generate
    if (CASC_SYNC) begin : g_casc_reg
      logic casc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) casc_q <= 1'b0;
        else         casc_q <= casc_tick_i;
      end
      assign casc_tick = casc_q;
    end else begin : g_casc_dir
      assign casc_tick = casc_tick_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
    end else if (restart_i) begin
      phase_q <= 1'b0;
    end else if (active_i && src_i == SRC_HALF) begin
      phase_q <= ~phase_q;
    end
  end

  always_comb begin
    tick_o = 1'b0;
    if (active_i && !restart_i) begin
      tick_o = (src_i == SRC_CASC) ? casc_tick : phase_q;
    end
  end
endmodule

// File: rtl/tmr13_down_cnt.sv
module tmr13_down_cnt #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             last;

  assign last = (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
      end else if (tick_i) begin
        if (last || cnt_q == '0) begin
          // zero stays parked when the programmed value is zero
          cnt_q <= reload_val_i;
          exp_q <= last;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/tmr13_top.sv
module tmr13_top
  import tmr13_pkg::*;
#(
  parameter int CNT_W     = 13,
  parameter bit CASC_SYNC = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [CNT_W+2:0]   wr_data_i,
  input  logic               casc_tick_i,
  output logic [CNT_W+2:0]   cfg_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               irq_o
);
  localparam int REG_W   = CNT_W + 3;
  localparam int SRC_BIT = CNT_W;
  localparam int RUN_BIT = CNT_W + 1;
  localparam int EN_BIT  = CNT_W + 2;

  logic [REG_W-1:0] cfg;
  logic             active;
  logic             tick;
  tick_src_e        src;

  tmr13_cfg_reg #(.REG_W(REG_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg)
  );

  assign active = cfg[EN_BIT] & cfg[RUN_BIT];
  assign src    = tick_src_e'(cfg[SRC_BIT]);

  tmr13_tick_gen #(.CASC_SYNC(CASC_SYNC)) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .src_i       (src),
    .restart_i   (wr_en_i),
    .casc_tick_i (casc_tick_i),
    .tick_o      (tick)
  );

  tmr13_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (wr_en_i),
    .load_val_i   (wr_data_i[CNT_W-1:0]),
    .tick_i       (tick),
    .reload_val_i (cfg[CNT_W-1:0]),
    .cnt_o        (count_o),
    .expire_o     (irq_o)
  );

  assign cfg_o = cfg;
endmodule

// File: rtl/tmr13_chk.sv
module tmr13_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [CNT_W+2:0] wr_data_i,
  input logic [CNT_W+2:0] cfg_o,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o
);
  localparam int RUN_BIT = CNT_W + 1;
  localparam int EN_BIT  = CNT_W + 2;

  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> count_o == $past(wr_data_i[CNT_W-1:0])); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(cfg_o[EN_BIT] && cfg_o[RUN_BIT]) && !wr_en_i) |=> $stable(count_o)); // R3

  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_o[EN_BIT] |=> !cfg_o[EN_BIT]); // R4

  AST_IRQ_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (count_o == cfg_o[CNT_W-1:0] && cfg_o[CNT_W-1:0] != '0)); // R7

  AST_IRQ_FROM_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(count_o) == CNT_W'(1) && !$past(wr_en_i))); // R9

  AST_ZERO_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0 && !wr_en_i) |=> (count_o == '0 && !irq_o)); // R8
endmodule

bind tmr13_top tmr13_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .cfg_o     (cfg_o),
  .count_o   (count_o),
  .irq_o     (irq_o)
);

// File: tb/sim_tmr13_top.sv
module sim_tmr13_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        casc_tick_i = 1'b0;
  logic [15:0] cfg_o;
  logic [12:0] count_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference state
  logic [15:0] m_cfg;
  logic [12:0] m_cnt;
  logic        m_ph;
  logic        m_irq;

  tmr13_top u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .casc_tick_i (casc_tick_i),
    .cfg_o       (cfg_o),
    .count_o     (count_o),
    .irq_o       (irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > WDOG_LIMIT) begin
      failures = failures + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cfg = 16'h8000; m_cnt = '0; m_ph = 1'b0; m_irq = 1'b0;
  endtask

  task automatic model_step(input logic wr, input logic [15:0] d, input logic casc);
    logic act, tk;
    act = m_cfg[15] & m_cfg[14];
    if (wr) begin
      m_cfg = {m_cfg[15] & d[15], d[14:0]};
      m_cnt = d[12:0]; m_ph = 1'b0; m_irq = 1'b0;
    end else begin
      tk = act & (m_cfg[13] ? casc : m_ph);
      m_irq = tk && (m_cnt == 13'd1);
      if (tk) m_cnt = (m_cnt <= 13'd1) ? m_cfg[12:0] : m_cnt - 13'd1;
      if (act && !m_cfg[13]) m_ph = ~m_ph;
    end
  endtask

  // called at a negedge; returns just after the next negedge
  task automatic step(input logic wr, input logic [15:0] d, input logic casc, input string req);
    wr_en_i = wr; wr_data_i = d; casc_tick_i = casc;
    @(posedge clk_i);
    model_step(wr, d, casc);
    #1;
    chk({req, " cfg"}, 32'(cfg_o), 32'(m_cfg));
    chk({req, " count"}, 32'(count_o), 32'(m_cnt));
    chk({req, " irq"}, 32'(irq_o), 32'(m_irq));
    @(negedge clk_i);
    wr_en_i = 1'b0; casc_tick_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_en_i = 1'b0; casc_tick_i = 1'b0;
    model_reset();
    @(negedge clk_i);
    chk("R1 cfg in reset", 32'(cfg_o), 32'h8000);
    chk("R1 count in reset", 32'(count_o), 32'h0);
    chk("R1 irq in reset", 32'(irq_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    int irq_hits;
    void'($urandom(32'd2024));
    model_reset();
    do_reset();
    step(1'b0, '0, 1'b0, "R1 idle after reset");

    // R5: value 8 on half-rate source -> irq at cycles 16 and 32
    step(1'b1, 16'hC008, 1'b0, "R2 write");
    irq_hits = 0;
    for (int k = 1; k <= 40; k++) begin
      step(1'b0, '0, 1'b0, "R5 half rate");
      if (irq_o) begin
        irq_hits++;
        chk("R5 irq cycle", 32'(k), (irq_hits == 1) ? 32'd16 : 32'd32);
      end
    end
    chk("R5 irq count", 32'(irq_hits), 32'd2);

    // R6: cascade source, value 3, tick on every other cycle
    step(1'b1, 16'hE003, 1'b0, "R2 write casc");
    for (int k = 1; k <= 6; k++) begin
      step(1'b0, '0, (k % 2) == 0, "R6 cascade");
      if (k < 6) chk("R6 no early irq", 32'(irq_o), 32'h0);
    end
    chk("R6 irq after third tick", 32'(irq_o), 32'h1);
    chk("R7 reload value", 32'(count_o), 32'd3);
    step(1'b0, '0, 1'b0, "R7 pulse width");
    chk("R7 irq one cycle", 32'(irq_o), 32'h0);

    // R8: zero value never interrupts
    step(1'b1, 16'hC000, 1'b0, "R8 write zero");
    irq_hits = 0;
    for (int k = 0; k < 40; k++) begin
      step(1'b0, '0, 1'b0, "R8 zero parked");
      if (irq_o) irq_hits++;
    end
    chk("R8 no irq", 32'(irq_hits), 32'd0);
    chk("R8 count zero", 32'(count_o), 32'd0);

    // R3: run cleared holds count
    step(1'b1, 16'h8005, 1'b0, "R3 write halted");
    for (int k = 0; k < 10; k++) step(1'b0, '0, 1'b1, "R3 halted");
    chk("R3 count held", 32'(count_o), 32'd5);

    // R9: rewrite on the expiry edge
    step(1'b1, 16'hC001, 1'b0, "R9 write one");
    step(1'b0, '0, 1'b0, "R9 phase");
    step(1'b1, 16'hC001, 1'b0, "R9 rewrite");
    chk("R9 irq suppressed", 32'(irq_o), 32'h0);
    step(1'b0, '0, 1'b0, "R9 restarted phase");
    chk("R9 no irq on odd edge", 32'(irq_o), 32'h0);
    step(1'b0, '0, 1'b0, "R9 expiry");
    chk("R9 irq after restart", 32'(irq_o), 32'h1);

    // random phase with enable kept set
    for (int k = 0; k < 4000; k++) begin
      logic wr;
      logic [15:0] d;
      wr = ($urandom % 24) == 0;
      d = 16'($urandom);
      d[15] = 1'b1;
      if (($urandom % 8) != 0) d[12:0] = 13'($urandom % 12);
      step(wr, d, 1'($urandom), "R2 R3 R5 R6 R7 random");
    end

    // R4: sticky enable
    step(1'b1, 16'h4005, 1'b0, "R4 clear enable");
    chk("R4 enable cleared", 32'(cfg_o[15]), 32'h0);
    step(1'b1, 16'hC007, 1'b0, "R4 try re-enable");
    chk("R4 enable stays off", 32'(cfg_o), 32'h4007);
    for (int k = 0; k < 20; k++) step(1'b0, '0, 1'b1, "R3 disabled holds");
    chk("R3 count held when disabled", 32'(count_o), 32'd7);
    for (int k = 0; k < 200; k++)
      step(($urandom % 10) == 0, 16'($urandom), 1'($urandom), "R4 random disabled");
    chk("R4 still disabled", 32'(cfg_o[15]), 32'h0);
    do_reset();
    chk("R1 enable back after reset", 32'(cfg_o), 32'h8000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule